// File: doc/BRIEF.md
# Gated 13-Bit Dual Timer/Counter

This block holds two independent timer/counter channels, each running as a 13-bit counter. Each count value is split across two byte registers. The high byte carries the top eight bits. The low five bits of the low byte carry the bottom five bits, so the low byte works as a divide-by-32 prescaler in front of the high byte. A channel advances either on an internal prescaled tick or on falling edges of its external count pin. Its run bit enables counting, and it can also be gated by its external gate pin, which lets the channel measure how long that pin stays high.

When a channel's 13-bit value wraps from all ones to zero, the channel raises its overflow flag. If its toggle enable is set, the wrap also inverts the channel's toggle output. The flag stays set until the interrupt logic acknowledges it or software writes a zero to it. Software reaches the control byte, the mode byte and the four count bytes through a simple register port. The write path is synchronous and the read path is combinational.

Top module: `gated_timer13`

## Requirements
- R1: After reset every register reads 00h, and both overflow flags and both toggle outputs are 0.
- R2: A channel's count value is {high byte, low byte bits 4:0}. It rises by exactly one for each accepted count pulse and wraps from 1FFFh to 0000h. A carry out of low-byte bit 4 increments the high byte.
- R3: Low-byte bits 7:5 read back the value last written and never take part in counting.
- R4: A count pulse is accepted only when the channel's run bit is 1 and either its gate bit is 0 or its gate pin is 1. In every other case the count holds.
- R5: A wrap from 1FFFh to 0000h sets that channel's overflow flag. The flag appears at control bit 5 and ovf_flag[0] for channel 0, and at control bit 7 and ovf_flag[1] for channel 1.
- R6: Writing a run bit to 1 leaves the count registers unchanged.
- R7: Mode source bit 0 selects the internal tick, and 1 selects the count pin. In pin mode, a falling edge of the synchronised pin is held until the next tick and is counted then. At most one pulse is counted per tick, and a tick with no pending edge adds nothing.
- R8: An irq_ack pulse clears the flag, and so does a control-register write with the flag bit at 0. A wrap in the same cycle as a clear leaves the flag set.
- R9: With the channel's toggle enable set, each wrap inverts its tgl_out. With the enable clear, tgl_out holds.
- R10: Register map: address 0 control ({flag1, run1, flag0, run0, 0000}), 1 mode, 2/3 channel 0 low/high, 4/5 channel 1 low/high. The mode byte holds channel 1 {gate, source, toggle enable} in bits 7:5 and channel 0 in bits 3:1, and reads back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| tick | input | 1 | Internal prescaled count enable, one cycle per tick |
| cnt_pin | input | 2 | External count pins, one per channel |
| gate_pin | input | 2 | External gate pins, one per channel (synchronous to clk) |
| irq_ack | input | 2 | Flag clear from the interrupt logic, one per channel |
| ovf_flag | output | 2 | Overflow flags |
| tgl_out | output | 2 | Overflow toggle outputs |

## Verification
A wrong carry or a wrong gating decision changes the count bytes on the first accepted tick. A read after a known number of ticks therefore exposes it within a handful of cycles. A dropped or misplaced flag or toggle shows on ovf_flag and tgl_out one cycle after the wrap edge. A lost or doubled pin edge shows as a count that differs from the number of edges driven, once the two-stage synchroniser has settled.

// File: rtl/tmr13_pkg.sv
// Package: shared constants and types for the gated 13-bit timer.
// Assumes a byte-wide register port and two channels.
package tmr13_pkg;
    localparam int DATA_W  = 8;
    localparam int LO_BITS = 5;
    localparam int HI_BITS = 8;
    localparam int CNT_W   = LO_BITS + HI_BITS;
    localparam int TOP_W   = DATA_W - LO_BITS;
    localparam int ADDR_W  = 3;
    localparam int NUM_CH  = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd1;

    // Per-channel mode fields, in the order they sit in the mode byte.
    typedef struct packed {
        logic gate;
        logic ext_src;
        logic tgl_en;
    } chan_mode_t;
endpackage

// File: rtl/tmr13_edge_pulse.sv
// Module: tmr13_edge_pulse
// Synchronises an external count pin and detects its falling edges.
// An edge is held pending until the next tick, so at most one count
// pulse leaves per tick. Assumes SYNC_STAGES >= 2.
module tmr13_edge_pulse #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic tick,
    output logic pulse
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         prev_q;
    logic         pend_q;
    logic         fall;

    assign fall  = prev_q & ~sync_q[MSB];
    assign pulse = tick & (pend_q | fall);

    // Shift the pin through the synchroniser and hold edges until a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[MSB-1:0], pin};
            prev_q <= sync_q[MSB];
            pend_q <= (pend_q | fall) & ~tick;
        end
    end
endmodule

// File: rtl/tmr13_channel.sv
// Module: tmr13_channel
// One 13-bit counting channel: the count register, the gating,
// the overflow flag and the toggle output. A software write to a
// count byte takes precedence over counting in the same cycle.
// A hardware flag set takes precedence over any clear.
module tmr13_channel
    import tmr13_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  chan_mode_t        mode,
    input  logic              gate_pin,
    input  logic              tick,
    input  logic              ext_pulse,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flag_wr,
    input  logic              flag_wr_val,
    input  logic              ack,
    output logic [DATA_W-1:0] lo_byte,
    output logic [DATA_W-1:0] hi_byte,
    output logic              flag,
    output logic              tgl
);
    logic [CNT_W-1:0] count_q;
    logic [TOP_W-1:0] lo_top_q;
    logic             flag_q;
    logic             tgl_q;
    logic             src;
    logic             accept;
    logic             wr_any;
    logic             wrap;

    assign src    = mode.ext_src ? ext_pulse : tick;
    assign wr_any = wr_lo | wr_hi;
    assign accept = run & (~mode.gate | gate_pin) & src & ~wr_any;
    assign wrap   = accept & (&count_q);

    // Load count bytes from software, otherwise advance on accepted pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            lo_top_q <= '0;
        end else if (wr_lo) begin
            count_q[LO_BITS-1:0] <= wr_data[LO_BITS-1:0];
            lo_top_q             <= wr_data[DATA_W-1:LO_BITS];
        end else if (wr_hi) begin
            count_q[CNT_W-1:LO_BITS] <= wr_data;
        end else if (accept) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Overflow flag: the wrap sets it, ack or a software write clears or sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (wrap)    flag_q <= 1'b1;
        else if (ack)     flag_q <= 1'b0;
        else if (flag_wr) flag_q <= flag_wr_val;
    end

    // Toggle output inverts on each wrap while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                  tgl_q <= 1'b0;
        else if (wrap && mode.tgl_en) tgl_q <= ~tgl_q;
    end

    assign lo_byte = {lo_top_q, count_q[LO_BITS-1:0]};
    assign hi_byte = count_q[CNT_W-1:LO_BITS];
    assign flag    = flag_q;
    assign tgl     = tgl_q;

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_any |=> (count_q == $past(count_q)) ||
                    (count_q == CNT_W'($past(count_q) + 1'b1)));
    // R3
    lo_top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> $stable(lo_top_q));
    // R4
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && (!mode.gate || gate_pin) && src) && !wr_any) |=> $stable(count_q));
    // R5
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && count_q == '1) |=> flag_q && count_q == '0);
    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wrap) |=> !flag_q);
    // R9
    tgl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wrap && mode.tgl_en) |=> $stable(tgl_q));
endmodule

// File: rtl/gated_timer13.sv
// Module: gated_timer13
// Two-channel gated 13-bit timer/counter with a byte register port.
// Holds the control and mode registers, decodes the address map and
// instantiates one counting channel plus one edge detector per channel.
// Assumes gate_pin and irq_ack are synchronous to clk.
module gated_timer13
    import tmr13_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tick,
    input  logic [NUM_CH-1:0] cnt_pin,
    input  logic [NUM_CH-1:0] gate_pin,
    input  logic [NUM_CH-1:0] irq_ack,
    output logic [NUM_CH-1:0] ovf_flag,
    output logic [NUM_CH-1:0] tgl_out
);
    logic [NUM_CH-1:0] run_q;
    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] lo_b [NUM_CH];
    logic [DATA_W-1:0] hi_b [NUM_CH];
    logic              ctrl_wr;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

    // Control run bits and the mode byte written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            mode_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) run_q  <= {wr_data[6], wr_data[4]};
            if (wr_addr == A_MODE) mode_q <= wr_data;
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int                MODE_LSB = 4 * i + 1;
        localparam int                FLAG_BIT = 2 * i + 5;
        localparam logic [ADDR_W-1:0] A_LO     = ADDR_W'(2 * i + 2);
        localparam logic [ADDR_W-1:0] A_HI     = ADDR_W'(2 * i + 3);

        logic       ext_pulse;
        chan_mode_t ch_mode;

        assign ch_mode = mode_q[MODE_LSB +: 3];

        tmr13_edge_pulse #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (cnt_pin[i]),
            .tick  (tick),
            .pulse (ext_pulse)
        );

        tmr13_channel u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .run         (run_q[i]),
            .mode        (ch_mode),
            .gate_pin    (gate_pin[i]),
            .tick        (tick),
            .ext_pulse   (ext_pulse),
            .wr_lo       (wr_en && (wr_addr == A_LO)),
            .wr_hi       (wr_en && (wr_addr == A_HI)),
            .wr_data     (wr_data),
            .flag_wr     (ctrl_wr),
            .flag_wr_val (wr_data[FLAG_BIT]),
            .ack         (irq_ack[i]),
            .lo_byte     (lo_b[i]),
            .hi_byte     (hi_b[i]),
            .flag        (ovf_flag[i]),
            .tgl         (tgl_out[i])
        );
    end

    // Combinational read multiplexer over the register map.
    always_comb begin
        case (rd_addr)
            3'd0:    rd_data = {ovf_flag[1], run_q[1], ovf_flag[0], run_q[0], 4'b0000};
            3'd1:    rd_data = mode_q;
            3'd2:    rd_data = lo_b[0];
            3'd3:    rd_data = hi_b[0];
            3'd4:    rd_data = lo_b[1];
            3'd5:    rd_data = hi_b[1];
            default: rd_data = '0;
        endcase
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (run_q == '0) && (mode_q == '0) && (ovf_flag == '0) && (tgl_out == '0));
endmodule

// File: tb/tb_gated_timer13.sv
module tb_gated_timer13;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tick = 1'b0;
    logic [1:0] cnt_pin = 2'b11;
    logic [1:0] gate_pin = 2'b00;
    logic [1:0] irq_ack = 2'b00;
    logic [1:0] ovf_flag;
    logic [1:0] tgl_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gated_timer13 dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick(tick), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
        .irq_ack(irq_ack), .ovf_flag(ovf_flag), .tgl_out(tgl_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic get_cnt(input int ch, output int v);
        logic [7:0] lo, hi;
        rd(3'(2 + 2 * ch), lo);
        rd(3'(3 + 2 * ch), hi);
        v = {hi, lo[4:0]};
    endtask

    task automatic load(input int ch, input int v);
        wr(3'(2 + 2 * ch), {3'b000, 5'(v)});
        wr(3'(3 + 2 * ch), 8'(v >> 5));
    endtask

    task automatic run_ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int v;
        int tg;
        int starts [8] = '{0, 1, 31, 32, 255, 4095, 8190, 8191};
        int lens   [5] = '{1, 2, 5, 33, 40};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1 reg", d, 0);
        end
        chk("R1 flags", ovf_flag, 0);
        chk("R1 toggles", tgl_out, 0);

        // R10 mode register readback
        wr(3'd1, 8'hEE);
        rd(3'd1, d);
        chk("R10 mode readback", d, 8'hEE);
        wr(3'd1, 8'h00);

        // R2 R5 sweep of start values and tick counts on channel 0
        foreach (starts[si]) begin
            foreach (lens[li]) begin
                wr(3'd0, 8'h00);
                load(0, starts[si]);
                wr(3'd0, 8'h10);
                run_ticks(lens[li]);
                get_cnt(0, v);
                chk("R2 count sweep", v, (starts[si] + lens[li]) % 8192);
                chk("R5 flag sweep", ovf_flag[0], int'((starts[si] + lens[li]) >= 8192));
                rd(3'd0, d);
                chk("R5 ctrl bit5", d[5], int'((starts[si] + lens[li]) >= 8192));
            end
        end
        chk("R9 toggle disabled holds", tgl_out[0], 0);

        // R3 upper low-byte bits kept and ignored
        wr(3'd0, 8'h00);
        wr(3'd2, 8'hBF);
        wr(3'd3, 8'h12);
        wr(3'd0, 8'h10);
        run_ticks(1);
        rd(3'd3, d);
        chk("R3 carry into high", d, 8'h13);
        rd(3'd2, d);
        chk("R3 top bits kept", d, 8'hA0);

        // R4 gating
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h08);
        load(0, 100);
        wr(3'd0, 8'h10);
        gate_pin[0] = 1'b0;
        run_ticks(10);
        get_cnt(0, v);
        chk("R4 gated low holds", v, 100);
        gate_pin[0] = 1'b1;
        run_ticks(10);
        get_cnt(0, v);
        chk("R4 gate high counts", v, 110);
        wr(3'd0, 8'h00);
        run_ticks(5);
        get_cnt(0, v);
        chk("R4 run off holds", v, 110);
        gate_pin[0] = 1'b0;
        wr(3'd1, 8'h00);
        // R6 run set keeps count
        wr(3'd0, 8'h10);
        get_cnt(0, v);
        chk("R6 run set no clear", v, 110);
        run_ticks(5);
        get_cnt(0, v);
        chk("R4 gate off counts", v, 115);

        // R7 external count pin on channel 1
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h40);
        load(1, 0);
        wr(3'd0, 8'h40);
        tick = 1'b1;
        for (int k = 0; k < 6; k++) begin
            cnt_pin[1] = 1'b0;
            repeat (4) @(negedge clk);
            cnt_pin[1] = 1'b1;
            repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        tick = 1'b0;
        get_cnt(1, v);
        chk("R7 edges counted", v, 6);
        for (int k = 0; k < 3; k++) begin
            cnt_pin[1] = 1'b0;
            repeat (4) @(negedge clk);
            cnt_pin[1] = 1'b1;
            repeat (4) @(negedge clk);
        end
        get_cnt(1, v);
        chk("R7 no tick no count", v, 6);
        run_ticks(1);
        get_cnt(1, v);
        chk("R7 one per tick", v, 7);
        run_ticks(5);
        get_cnt(1, v);
        chk("R7 tick ignored without edge", v, 7);

        // R5 channel 1 flag position
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
        load(1, 8190);
        wr(3'd0, 8'h40);
        run_ticks(3);
        rd(3'd0, d);
        chk("R5 ch1 ctrl bit7", d[7], 1);
        chk("R5 ch1 ctrl bit5 clear", d[5], 0);
        chk("R5 ch1 ovf_flag", ovf_flag, 2'b10);
        get_cnt(1, v);
        chk("R2 ch1 wrap value", v, 1);

        // R8 clearing paths and set priority
        wr(3'd0, 8'h00);
        load(0, 8191);
        wr(3'd0, 8'h10);
        run_ticks(1);
        chk("R8 flag set", ovf_flag[0], 1);
        irq_ack[0] = 1'b1;
        @(negedge clk);
        irq_ack[0] = 1'b0;
        chk("R8 ack clears", ovf_flag[0], 0);
        wr(3'd0, 8'h00);
        load(0, 8191);
        wr(3'd0, 8'h10);
        run_ticks(1);
        wr(3'd0, 8'h10);
        chk("R8 sw write clears", ovf_flag[0], 0);
        wr(3'd0, 8'h00);
        load(0, 8191);
        wr(3'd0, 8'h10);
        tick = 1'b1;
        irq_ack[0] = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        irq_ack[0] = 1'b0;
        chk("R8 set beats ack", ovf_flag[0], 1);

        // R9 toggle on every wrap
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h02);
        tg = tgl_out[0];
        for (int k = 0; k < 3; k++) begin
            wr(3'd0, 8'h00);
            load(0, 8190);
            wr(3'd0, 8'h10);
            run_ticks(2);
            tg = 1 - tg;
            chk("R9 toggle per wrap", tgl_out[0], tg);
        end
        run_ticks(4);
        chk("R9 no wrap holds", tgl_out[0], tg);
        chk("R9 ch1 untouched", tgl_out[1], 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule